// File: doc/BRIEF.md
# Column Mixer with Iterated Inverse

This block performs the column-mixing step of a compact 128-bit block cipher, one 32-bit column (four bytes) per operation. It builds only the forward mixing matrix over GF(2^8). The inverse of that matrix is the forward matrix raised to the third power. Decryption therefore reuses the same circuit: the column is passed through it three times in a row, with the result of each pass fed back as the input to the next.

A caller presents a column and a mode, then pulses `start`. An encrypt operation finishes one clock later. A decrypt operation finishes three clocks later. In both cases `done` pulses for one cycle, and `colOut` holds the result until the next accepted start. The round state storage and the other round operations live outside this block.

Top module: `colmix_top`

## Requirements
- R1: After reset, `done` is 0 and `colOut` is 0.
- R2: Byte a0 is `colIn[31:24]` and a3 is `colIn[7:0]`, and the output uses the same byte order. One forward pass produces out_i = 2*a_i xor 3*a_(i+1) xor a_(i+2) xor a_(i+3), with indices taken mod 4. For example, {db,13,53,45} maps to {8e,4d,a1,bc}.
- R3: Multiplying by 2 shifts the byte left by one bit. If the bit shifted out is 1, the result is also xored with 0x1B. For example, {80,00,00,00} maps to {1b,80,80,9b}, and {40,00,00,00} maps to {80,40,40,c0}.
- R4: With `decrypt`=0, a start sampled at one rising edge gives `done`=1, with the forward result on `colOut`, in the following cycle.
- R5: With `decrypt`=1, `done` stays 0 for the two cycles after the start edge. It rises in the third cycle, and `colOut` then holds the forward transform applied three times.
- R6: A decrypt undoes an encrypt. For example, decrypting {8e,4d,a1,bc} returns {db,13,53,45}, and decrypt(encrypt(x)) = x for any column x.
- R7: `done` is a single-cycle pulse unless a new start is accepted in the same cycle. `colOut` does not change between operations.
- R8: A start raised while a decrypt is still in progress is ignored. The running result and its completion cycle are unchanged.
- R9: `decrypt` and `colIn` are sampled only at the accepted start. Changing them during a decrypt has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation on `colIn` |
| decrypt | input | 1 | 1 selects the inverse (three passes), 0 selects forward (one pass) |
| colIn | input | 32 | Input column, byte 0 in bits 31:24 |
| colOut | output | 32 | Result column, held until the next accepted start |
| done | output | 1 | One-cycle pulse when `colOut` holds a new result |

## Verification
On every cycle, the assertions check the following:
- `done` follows an accepted encrypt start and never follows a decrypt start directly.
- A decrypt in progress keeps running while passes remain.
- `done` drops after one cycle.
- `colOut` stays still when no strobe loads it.
- Every pass preserves the xor of the four bytes, which holds because the matrix row sums to 1.

Only the bench scenarios can show the following:
- The actual byte values, including the reduction by 0x1B.
- That three forward passes invert one pass.
- That inputs and starts changed during a decrypt leave the result alone.

// File: rtl/colmix_pkg.sv
package colmix_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES = 4;
  localparam int COL_W = BYTE_W * LANES;
  localparam logic [BYTE_W-1:0] REDUCE_POLY = 8'h1B;
  localparam int DEC_PASSES = 3;
  localparam int PASS_CNT_W = $clog2(DEC_PASSES + 1);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [COL_W-1:0] col_t;

  typedef struct packed {
    logic load;   // mix colIn into the result register
    logic feed;   // mix the result register back into itself
  } strobe_t;

  function automatic byte_t gfDouble(input byte_t a);
    byte_t sh;
    sh = {a[BYTE_W-2:0], 1'b0};
    return a[BYTE_W-1] ? (sh ^ REDUCE_POLY) : sh;
  endfunction

  function automatic byte_t laneOf(input col_t c, input int idx);
    return c[COL_W-1-BYTE_W*idx -: BYTE_W];
  endfunction

  function automatic byte_t foldBytes(input col_t c);
    byte_t acc;
    acc = '0;
    for (int k = 0; k < LANES; k++) acc ^= laneOf(c, k);
    return acc;
  endfunction
endpackage

// File: rtl/colmix_mixer.sv
module colmix_mixer
  import colmix_pkg::*;
(
  input  col_t colSrc,
  output col_t colMix
);
  byte_t srcLane [LANES];
  byte_t dblLane [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign srcLane[i] = colSrc[COL_W-1-BYTE_W*i -: BYTE_W];
    assign dblLane[i] = gfDouble(srcLane[i]);
    // 2*a_i ^ 3*a_(i+1) ^ a_(i+2) ^ a_(i+3)
    assign colMix[COL_W-1-BYTE_W*i -: BYTE_W] =
        dblLane[i]
      ^ dblLane[(i+1)%LANES] ^ srcLane[(i+1)%LANES]
      ^ srcLane[(i+2)%LANES]
      ^ srcLane[(i+3)%LANES];
  end

  // R2: the circulant row sums to 1, so the byte xor is preserved
  always_comb begin
    a_r2_fold_kept: assert (foldBytes(colMix) == foldBytes(colSrc))
      else $error("mixer changed byte fold");
  end
endmodule

// File: rtl/colmix_datapath.sv
module colmix_datapath
  import colmix_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  col_t    colIn,
  output col_t    colOut
);
  col_t colReg;
  col_t mixSrc;
  col_t mixRes;

  assign mixSrc = strobe.load ? colIn : colReg;

  colmix_mixer mixer_i (
    .colSrc (mixSrc),
    .colMix (mixRes)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           colReg <= '0;
    else if (strobe.load || strobe.feed) colReg <= mixRes;
  end

  assign colOut = colReg;

  // R7: result register holds when no strobe is raised
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.feed) |=> $stable(colOut));
  // R2: every registered pass keeps the byte fold of its source
  a_r2_pass_fold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load || strobe.feed) |=> foldBytes(colOut) == $past(foldBytes(mixSrc)));
endmodule

// File: rtl/colmix_ctrl.sv
module colmix_ctrl
  import colmix_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    decrypt,
  output strobe_t strobe,
  output logic    done
);
  logic                  running;
  logic [PASS_CNT_W-1:0] passLeft;
  logic                  accept;

  assign accept      = start && !running;
  assign strobe.load = accept;
  assign strobe.feed = running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      passLeft <= '0;
      done     <= 1'b0;
    end else if (accept) begin
      running  <= decrypt;
      passLeft <= PASS_CNT_W'(DEC_PASSES - 1);
      done     <= !decrypt;
    end else if (running) begin
      passLeft <= passLeft - 1'b1;
      if (passLeft == PASS_CNT_W'(1)) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else begin
        done    <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // R4: encrypt completes in the next cycle
  a_r4_enc_next: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !decrypt) |=> done);
  // R5: decrypt never completes one cycle after its start
  a_r5_dec_not_early: assert property (@(posedge clk) disable iff (!rstN)
    (accept && decrypt) |=> !done);
  // R8: a decrypt with passes left keeps running whatever start does
  a_r8_keep_running: assert property (@(posedge clk) disable iff (!rstN)
    (running && passLeft > PASS_CNT_W'(1)) |=> (running && !done));
  // R7: done drops unless a new start is taken
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done);
  // R5: pass counter never exceeds the pass count
  a_r5_pass_bound: assert property (@(posedge clk) disable iff (!rstN)
    passLeft <= PASS_CNT_W'(DEC_PASSES - 1));
endmodule

// File: rtl/colmix_top.sv
module colmix_top
  import colmix_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        decrypt,
  input  logic [31:0] colIn,
  output logic [31:0] colOut,
  output logic        done
);
  strobe_t strobe;

  colmix_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .decrypt (decrypt),
    .strobe  (strobe),
    .done    (done)
  );

  colmix_datapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .colIn  (colIn),
    .colOut (colOut)
  );
endmodule

// File: tb/colmix_top_tb_top.sv
`timescale 1ns/1ps
module colmix_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        decrypt = 1'b0;
  logic [31:0] colIn = '0;
  logic [31:0] colOut;
  logic        done;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  colmix_top dut_i (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt),
    .colIn(colIn), .colOut(colOut), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, leave one rising edge to sample start
  task automatic kick(input logic dec, input logic [31:0] col);
    @(negedge clk);
    start = 1'b1; decrypt = dec; colIn = col;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runEnc(input logic [31:0] col, output logic [31:0] res);
    kick(1'b0, col);
    check("R4 done", {31'b0, done}, 32'd1);
    res = colOut;
  endtask

  task automatic runDec(input logic [31:0] col, output logic [31:0] res);
    kick(1'b1, col);
    check("R5 done low c1", {31'b0, done}, 32'd0);
    @(negedge clk);
    check("R5 done low c2", {31'b0, done}, 32'd0);
    @(negedge clk);
    check("R5 done c3", {31'b0, done}, 32'd1);
    res = colOut;
  endtask

  task automatic testReset();
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 colOut", colOut, 32'h0);
  endtask

  task automatic testForward();
    logic [31:0] r;
    runEnc(32'hdb135345, r); check("R2 db135345", r, 32'h8e4da1bc);
    runEnc(32'hf20a225c, r); check("R2 f20a225c", r, 32'h9fdc589d);
    runEnc(32'hd4d4d4d5, r); check("R2 d4d4d4d5", r, 32'hd5d5d7d6);
    runEnc(32'hc6c6c6c6, r); check("R2 c6c6c6c6", r, 32'hc6c6c6c6);
  endtask

  task automatic testReduce();
    logic [31:0] r;
    runEnc(32'h80000000, r); check("R3 reduce", r, 32'h1b80809b);
    runEnc(32'h40000000, r); check("R3 no reduce", r, 32'h804040c0);
  endtask

  task automatic testInverse();
    logic [31:0] r, y;
    logic [31:0] vec [4] = '{32'h01234567, 32'hffffffff, 32'h80808080, 32'hdeadbeef};
    runDec(32'h8e4da1bc, r); check("R6 8e4da1bc", r, 32'hdb135345);
    runDec(32'h8e4da1bc, r); check("R5 three passes", r, 32'hdb135345);
    foreach (vec[k]) begin
      runEnc(vec[k], y);
      runDec(y, r);
      check("R6 roundtrip", r, vec[k]);
    end
  endtask

  task automatic testPulseHold();
    logic [31:0] r;
    runEnc(32'hdb135345, r);
    @(negedge clk);
    check("R7 pulse", {31'b0, done}, 32'd0);
    colIn = 32'h12345678;
    repeat (3) @(negedge clk);
    check("R7 hold", colOut, 32'h8e4da1bc);
  endtask

  task automatic testBusyIgnore();
    kick(1'b1, 32'h8e4da1bc);
    start = 1'b1; decrypt = 1'b0; colIn = 32'hffffffff;   // R8 start while busy
    @(negedge clk);
    check("R8 done low", {31'b0, done}, 32'd0);
    start = 1'b0; colIn = 32'h00000001;                   // R9 inputs change mid-run
    @(negedge clk);
    check("R8 done on time", {31'b0, done}, 32'd1);
    check("R9 result", colOut, 32'hdb135345);
    @(negedge clk);
    check("R8 no extra done", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testForward();
    testReduce();
    testInverse();
    testPulseHold();
    testBusyIgnore();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule